// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands one bit of the multiplier at a time. A start pulse in the idle state captures the operands. The multiplicand goes into a double-width register that shifts left, the multiplier goes into a register that shifts right, and the product register is cleared. Each iteration adds the shifted multiplicand to the product when the multiplier's lowest bit is set. The multiplicand and multiplier registers then move one place.

The loop ends as soon as the multiplier register is empty, so small multipliers finish early. The controller is a Moore machine, and its present state is driven on a port for observation. A one-cycle `done_valid` marks the cycle in which `prod` must be taken. `prod` keeps that value until the next accepted start.

Top module: `shiftadd_mul`

## Requirements
- R1: When `done_valid` is high, `prod` equals `op_a * op_b` as captured at the accepting edge, as an unsigned 16-bit value.
- R2: Let k be the bit length of the captured multiplier B (0 for B=0, 8 for B=0xFF). Count the accepting rising edge as edge 1. `done_valid` is first high after rising edge 2k+2: B=0 gives 2, B=3 gives 6, B=0xFF gives 18.
- R3: During an add/shift step, the product register only adds the shifted multiplicand, so it never decreases within a run.
- R4: `state_code` is 0 for idle, 1 for the zero test, 2 for the add/shift step and 3 for done. State 3 is entered only when the multiplier register is zero.
- R5: `done_valid` is high for exactly one cycle, only while `state_code` is 3, and the next state is 0.
- R6: Once a start is accepted, changes on `op_a`/`op_b` do not alter the result of that run.
- R7: A start that is high in state 3 is not accepted. The cycle after done is always state 0, and a start that is held high is taken from state 0, moving to state 1.
- R8: A synchronous active-high `rst` forces `state_code` 0, `prod` 0 and `done_valid` 0 after the next rising edge.
- R9: After done, `prod` holds its value in state 0 until a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication; accepted only in state 0 |
| op_a | input | 8 | Multiplicand (unsigned) |
| op_b | input | 8 | Multiplier (unsigned) |
| prod | output | 16 | Product register |
| done_valid | output | 1 | One-cycle result strobe |
| state_code | output | 2 | Present controller state (0 idle, 1 test, 2 step, 3 done) |

## Verification
The bench drives a start and counts rising edges from the accepting one. It then samples `done_valid` at each falling edge. The strobe must first appear exactly at edge 2k+2, where k is the bench's own bit-length count of B, and the product is compared with A*B at that sample. At the falling edge one edge later, the bench expects the strobe low and state 0. It then checks that the held product persists, or, when start is held high, that state 1 follows one edge after that.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TEST = 2'd1,
    ST_STEP = 2'd2,
    ST_DONE = 2'd3
  } mul_state_t;

  // One accumulation step: add the aligned multiplicand when the selector bit is set.
  function automatic logic [15:0] accum_step(input logic [15:0] acc,
                                             input logic [15:0] addend,
                                             input logic        sel);
    return sel ? (acc + addend) : acc;
  endfunction

endpackage

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [OP_W-1:0]   a_in,
  input  logic [OP_W-1:0]   b_in,
  output logic [PROD_W-1:0] prod,
  output logic              mplier_zero
);

  logic [PROD_W-1:0] mcand_q;
  logic [OP_W-1:0]   mplier_q;
  logic [PROD_W-1:0] sum_sel;

  // Adder plus bypass multiplexer feeding the product register.
  always_comb begin
    if (PROD_W == 16) sum_sel = mul_pkg::accum_step(prod, mcand_q, mplier_q[0]);
    else              sum_sel = mplier_q[0] ? (prod + mcand_q) : prod;
  end

  assign mplier_zero = (mplier_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod     <= '0;
    end else if (load) begin
      mcand_q  <= {{OP_W{1'b0}}, a_in};
      mplier_q <= b_in;
      prod     <= '0;
    end else if (step) begin
      prod     <= sum_sel;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mplier_zero,
  output mul_state_t state,
  output logic       accept,
  output logic       step,
  output logic       done
);

  mul_state_t nxt;

  // Next-state logic
  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_TEST;
      ST_TEST: nxt = mplier_zero ? ST_DONE : ST_STEP;
      ST_STEP: nxt = ST_TEST;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  // Output logic
  always_comb begin
    accept = (state == ST_IDLE) && start;
    step   = (state == ST_STEP);
    done   = (state == ST_DONE);
  end

endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [PROD_W-1:0] prod,
  output logic              done_valid,
  output logic [1:0]        state_code
);

  mul_pkg::mul_state_t st;
  logic accept_w;     // start taken this cycle
  logic step_w;       // add/shift this cycle
  logic mplier_zero;  // multiplier register empty

  mul_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mplier_zero (mplier_zero),
    .state       (st),
    .accept      (accept_w),
    .step        (step_w),
    .done        (done_valid)
  );

  mul_datapath #(.OP_W(OP_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .load        (accept_w),
    .step        (step_w),
    .a_in        (op_a),
    .b_in        (op_b),
    .prod        (prod),
    .mplier_zero (mplier_zero)
  );

  assign state_code = st;

endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int OP_W = 8,
  localparam int PROD_W = 2 * OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OP_W-1:0]   op_a,
  input logic [OP_W-1:0]   op_b,
  input logic [PROD_W-1:0] prod,
  input logic              done_valid,
  input logic [1:0]        state_code,
  input logic              accept_w,
  input logic              mplier_zero
);

  logic [PROD_W-1:0] a_cap = '0;
  logic [PROD_W-1:0] b_cap = '0;
  logic              rst_q = 1'b0;
  logic              seen  = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (accept_w && !rst) begin
      a_cap <= PROD_W'(op_a);
      b_cap <= PROD_W'(op_b);
      seen  <= 1'b1;
    end
  end

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    (done_valid && seen) |-> (prod == PROD_W'(a_cap * b_cap)));

  assert_accum_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd2) |=> (prod >= $past(prod)));

  assert_done_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd3) |-> mplier_zero);

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_valid_state_R5: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (state_code == 2'd3));

  assert_done_to_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd3) |=> (state_code == 2'd0));

  assert_reset_R8: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (state_code == 2'd0 && prod == '0 && !done_valid));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'd0 && !start) |=> $stable(prod));

endmodule

bind shiftadd_mul shiftadd_mul_chk #(.OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .op_a        (op_a),
  .op_b        (op_b),
  .prod        (prod),
  .done_valid  (done_valid),
  .state_code  (state_code),
  .accept_w    (accept_w),
  .mplier_zero (mplier_zero)
);

// File: tb/shiftadd_mul_bench.sv
`timescale 1ns/1ps
module shiftadd_mul_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic [15:0] prod;
  logic        done_valid;
  logic [1:0]  state_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  shiftadd_mul u_shiftadd_mul (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op_a       (op_a),
    .op_b       (op_b),
    .prod       (prod),
    .done_valid (done_valid),
    .state_code (state_code)
  );

  function automatic int bitlen(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) if (v[i]) n = i + 1;
    return n;
  endfunction

  function automatic int exp_prod(input logic [7:0] a, input logic [7:0] b);
    int s = 0;
    for (int i = 0; i < 8; i++) if (b[i]) s += int'(a) * (1 << i);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Runs one multiplication; optionally scrambles operands mid-run (R6).
  task automatic run(input logic [7:0] a, input logic [7:0] b, input bit scramble);
    int edges;
    int lat;
    lat = 2 * bitlen(b) + 2;
    @(negedge clk); op_a = a; op_b = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0; edges = 1;
    if (scramble) begin op_a = ~a; op_b = b ^ 8'h5A; end
    while (!done_valid && edges < 60) begin
      @(posedge clk); edges++;
      @(negedge clk);
    end
    chk(done_valid == 1'b1, "R2", "strobe seen", int'(done_valid), 1);
    chk(edges == lat, "R2", "latency edges", edges, lat);
    chk(int'(prod) == exp_prod(a, b), scramble ? "R6" : "R1", "product", int'(prod), exp_prod(a, b));
    chk(state_code == 2'd3, "R4", "done state code", int'(state_code), 3);
    @(posedge clk); @(negedge clk);
    chk(done_valid == 1'b0, "R5", "strobe one cycle", int'(done_valid), 0);
    chk(state_code == 2'd0, "R5", "back to idle", int'(state_code), 0);
    @(posedge clk); @(negedge clk);
    chk(int'(prod) == exp_prod(a, b), "R9", "held product", int'(prod), exp_prod(a, b));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk(state_code == 2'd0, "R8", "reset state", int'(state_code), 0);
    chk(prod == 16'd0, "R8", "reset product", int'(prod), 0);
    chk(done_valid == 1'b0, "R8", "reset strobe", int'(done_valid), 0);

    // Directed corner cases
    run(8'hFF, 8'hFF, 1'b0);
    run(8'h03, 8'h02, 1'b0);
    run(8'h00, 8'hFF, 1'b0);
    run(8'hFF, 8'h00, 1'b0);
    run(8'h00, 8'h00, 1'b0);
    run(8'h01, 8'h01, 1'b0);
    run(8'h80, 8'h80, 1'b0);
    run(8'hA5, 8'h81, 1'b1);

    // R7: start held high through done
    @(negedge clk); op_a = 8'h07; op_b = 8'h03; start = 1'b1;
    @(posedge clk);
    begin
      int guard = 0;
      @(negedge clk);
      while (!done_valid && guard < 40) begin
        @(posedge clk); @(negedge clk); guard++;
      end
    end
    chk(int'(prod) == 21, "R1", "held-start product", int'(prod), 21);
    @(posedge clk); @(negedge clk);
    chk(state_code == 2'd0, "R7", "no accept in done", int'(state_code), 0);
    @(posedge clk); @(negedge clk);
    chk(state_code == 2'd1, "R7", "accept from idle", int'(state_code), 1);
    start = 1'b0;
    repeat (12) @(posedge clk);

    // R8: reset in the middle of a run
    @(negedge clk); op_a = 8'hC3; op_b = 8'hF0; start = 1'b1;
    @(posedge clk); @(negedge clk); start = 1'b0;
    repeat (9) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(state_code == 2'd0, "R8", "mid-run reset state", int'(state_code), 0);
    chk(prod == 16'd0, "R8", "mid-run reset product", int'(prod), 0);
    chk(done_valid == 1'b0, "R8", "mid-run reset strobe", int'(done_valid), 0);
    rst = 1'b0;

    // Random operand pairs, some with mid-run operand changes
    for (int n = 0; n < 400; n++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      if (n % 7 == 0) rb = rb >> ($urandom % 8);
      run(ra, rb, (n % 5 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule